// File: doc/BRIEF.md
# Lockable System Control Register Bank

This block is a small bank of system control registers on a 32-bit register bus. The bus has a 4 KB window and word-aligned offsets. Software reads a fixed identity word and drives a general-purpose LED register. It keeps two sets of flag bits: one set is cleared by the ordinary block reset, and the other survives that reset and is cleared only by a power-on reset input. Each flag set has one address that sets bits (write ones to set) and another that clears bits (write ones to clear). A free-running tick counter advances on every cycle in which a 24 MHz clock-enable input is high, and software can read it.

A reset-level register is guarded by a key register. A write to the reset-level register is accepted only while the key register holds the unlock pattern. An accepted write that has the trigger bit set (chosen by a parameter) makes the block issue a one-cycle reset request toward the chip's reset controller. Offsets that the bank does not define read as zero and ignore writes, and any access to one of them raises a one-cycle error strobe.

Every request is a single cycle. Read data, the error strobe and the reset request all appear in the cycle after the request cycle.

Top module: `sysreg_bank`

## Requirements
- R1: After `rst` and `pwr_on_rst` have both been applied, reads return zero for the LED register (0x08), the key register (0x20), both flag sets (0x30 and 0x38), the reset-level register (0x40) and, while `tick_en` stays low, the tick counter (0x5C). `rd_valid`, `err_pulse` and `rst_req` are low.
- R2: A read request drives `rd_valid` high, with `rd_data`, exactly one cycle after the request cycle. No other cycle drives `rd_valid` high.
- R3: Offset 0x00 returns the `ID_WORD` parameter, and writes to it change nothing. Offset 0x44 always returns 1.
- R4: Offset 0x08 holds a full 32-bit LED value that is written and read back unchanged.
- R5: Writing the 32-bit value 0x0000A05F to offset 0x20 stores 0xA05F and opens the lock. Any other written value stores its low 16 bits with bit 15 forced to 0, which leaves the lock closed. Reads of 0x20 return the stored 16 bits, zero-extended.
- R6: Offset 0x30 reads the volatile flags and ORs a written value into them. A write to 0x34 clears every flag bit that is 1 in the written value. Offset 0x34 reads as zero.
- R7: The non-volatile flags behave the same way at 0x38 (read and set) and 0x3C (clear). `rst` leaves them unchanged and `pwr_on_rst` clears them. `pwr_on_rst` touches nothing else.
- R8: A write to offset 0x40 stores the full 32-bit value only while the lock is open. While the lock is closed the write is ignored.
- R9: `rst_req` pulses for exactly one cycle, in the cycle after an accepted 0x40 write whose bit `TRIG_BIT` is 1. There is no pulse for a locked write or for a write with that bit at 0.
- R10: The tick counter increments by one at each clock edge where `tick_en` is high. A read of 0x5C returns the count as it stood during the request cycle.
- R11: Any offset other than 0x00, 0x08, 0x20, 0x30, 0x34, 0x38, 0x3C, 0x40, 0x44 or 0x5C, including addresses that are not word-aligned, reads as zero and ignores writes. An access to such an offset raises `err_pulse` for one cycle, one cycle after the request. Defined offsets never raise it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high block reset |
| pwr_on_rst | input | 1 | Synchronous active-high power-on reset; clears only the non-volatile flags |
| tick_en | input | 1 | 24 MHz clock enable for the tick counter |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset within the window |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after a read) |
| rd_data | output | 32 | Read data |
| err_pulse | output | 1 | One-cycle strobe after an access to an undefined offset |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The case that needs care is a counter read issued in the same cycle that `tick_en` is high. In that cycle the register bank captures the count and the counter steps forward at the same clock edge. The bench runs a tick pattern with runs of consecutive high cycles and issues back-to-back reads of 0x5C across it. Its scoreboard monitor samples the count from its own tick model at the request edge, before it applies that edge's increment. The read must return that pre-increment value, and the next read must show the step.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

    localparam int unsigned ADDR_W     = 12;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned KEY_W      = 16;
    localparam int unsigned FLAG_BANKS = 2;

    localparam logic [ADDR_W-1:0] OFF_ID   = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_LED  = 12'h008;
    localparam logic [ADDR_W-1:0] OFF_KEY  = 12'h020;
    localparam logic [ADDR_W-1:0] OFF_VSET = 12'h030;
    localparam logic [ADDR_W-1:0] OFF_VCLR = 12'h034;
    localparam logic [ADDR_W-1:0] OFF_NSET = 12'h038;
    localparam logic [ADDR_W-1:0] OFF_NCLR = 12'h03C;
    localparam logic [ADDR_W-1:0] OFF_RLVL = 12'h040;
    localparam logic [ADDR_W-1:0] OFF_ONE  = 12'h044;
    localparam logic [ADDR_W-1:0] OFF_TICK = 12'h05C;

    localparam logic [DATA_W-1:0] KEY_OPEN = 32'h0000_A05F;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_ID,
        SEL_LED,
        SEL_KEY,
        SEL_VSET,
        SEL_VCLR,
        SEL_NSET,
        SEL_NCLR,
        SEL_RLVL,
        SEL_ONE,
        SEL_TICK
    } sel_e;

    typedef struct packed {
        logic led;
        logic key;
        logic rlvl;
        logic [FLAG_BANKS-1:0] fset;
        logic [FLAG_BANKS-1:0] fclr;
    } wr_hit_t;

    function automatic sel_e decode_offset(input logic [ADDR_W-1:0] a);
        case (a)
            OFF_ID:   return SEL_ID;
            OFF_LED:  return SEL_LED;
            OFF_KEY:  return SEL_KEY;
            OFF_VSET: return SEL_VSET;
            OFF_VCLR: return SEL_VCLR;
            OFF_NSET: return SEL_NSET;
            OFF_NCLR: return SEL_NCLR;
            OFF_RLVL: return SEL_RLVL;
            OFF_ONE:  return SEL_ONE;
            OFF_TICK: return SEL_TICK;
            default:  return SEL_NONE;
        endcase
    endfunction

    // Value kept by the key register for a given write.
    function automatic logic [KEY_W-1:0] key_next(input logic [DATA_W-1:0] w);
        if (w == KEY_OPEN) begin
            return KEY_OPEN[KEY_W-1:0];
        end
        return {1'b0, w[KEY_W-2:0]};
    endfunction

endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode
    import sysreg_pkg::*;
(
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output sel_e              sel,
    output wr_hit_t           wr_hit,
    output logic              rd_en,
    output logic              bad_acc
);

    always_comb begin
        sel     = decode_offset(req_addr);
        rd_en   = req_valid && !req_write;
        bad_acc = req_valid && (sel == SEL_NONE);

        wr_hit          = '0;
        if (req_valid && req_write) begin
            wr_hit.led     = (sel == SEL_LED);
            wr_hit.key     = (sel == SEL_KEY);
            wr_hit.rlvl    = (sel == SEL_RLVL);
            wr_hit.fset[0] = (sel == SEL_VSET);
            wr_hit.fclr[0] = (sel == SEL_VCLR);
            wr_hit.fset[1] = (sel == SEL_NSET);
            wr_hit.fclr[1] = (sel == SEL_NCLR);
        end
    end

endmodule

// File: rtl/sysreg_setclr.sv
module sysreg_setclr #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         clr_all,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] val
);

    always_ff @(posedge clk) begin
        if (clr_all) begin
            val <= '0;
        end else if (set_en) begin
            val <= val | wdata;
        end else if (clr_en) begin
            val <= val & ~wdata;
        end
    end

endmodule

// File: rtl/sysreg_ticker.sv
module sysreg_ticker #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_en,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (tick_en) begin
            count <= count + ONE;
        end
    end

endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
    import sysreg_pkg::*;
#(
    parameter logic [31:0] ID_WORD  = 32'h0100_0000,
    parameter int unsigned TRIG_BIT = 8,
    parameter int unsigned FLAG_W   = 32,
    parameter int unsigned CNT_W    = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pwr_on_rst,
    input  logic        tick_en,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [11:0] req_addr,
    input  logic [31:0] req_wdata,
    output logic        rd_valid,
    output logic [31:0] rd_data,
    output logic        err_pulse,
    output logic        rst_req
);

    sel_e              sel;
    wr_hit_t           wr_hit;
    logic              rd_en;
    logic              bad_acc;

    logic [DATA_W-1:0] led_q;
    logic [KEY_W-1:0]  key_q;
    logic              key_open;
    logic [DATA_W-1:0] rlvl_q;
    logic              rlvl_take;
    logic [CNT_W-1:0]  tick_cnt;
    logic [DATA_W-1:0] rd_mux;

    logic [FLAG_W-1:0]     flag_val  [FLAG_BANKS];
    logic [FLAG_BANKS-1:0] bank_clr;

    sysreg_decode u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .sel       (sel),
        .wr_hit    (wr_hit),
        .rd_en     (rd_en),
        .bad_acc   (bad_acc)
    );

    // Bank 0 follows the block reset, bank 1 only the power-on reset.
    assign bank_clr[0] = rst;
    assign bank_clr[1] = pwr_on_rst;

    for (genvar g = 0; g < FLAG_BANKS; g++) begin : g_flags
        sysreg_setclr #(.W(FLAG_W)) u_bank (
            .clk     (clk),
            .clr_all (bank_clr[g]),
            .set_en  (wr_hit.fset[g]),
            .clr_en  (wr_hit.fclr[g]),
            .wdata   (req_wdata[FLAG_W-1:0]),
            .val     (flag_val[g])
        );
    end

    sysreg_ticker #(.W(CNT_W)) u_ticker (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .count   (tick_cnt)
    );

    assign key_open  = (key_q == KEY_OPEN[KEY_W-1:0]);
    assign rlvl_take = wr_hit.rlvl && key_open;

    always_ff @(posedge clk) begin
        if (rst) begin
            led_q   <= '0;
            key_q   <= '0;
            rlvl_q  <= '0;
            rst_req <= 1'b0;
        end else begin
            if (wr_hit.led) begin
                led_q <= req_wdata;
            end
            if (wr_hit.key) begin
                key_q <= key_next(req_wdata);
            end
            if (rlvl_take) begin
                rlvl_q <= req_wdata;
            end
            rst_req <= rlvl_take && req_wdata[TRIG_BIT];
        end
    end

    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_ID:   rd_mux = ID_WORD;
            SEL_LED:  rd_mux = led_q;
            SEL_KEY:  rd_mux = DATA_W'(key_q);
            SEL_VSET: rd_mux = DATA_W'(flag_val[0]);
            SEL_NSET: rd_mux = DATA_W'(flag_val[1]);
            SEL_RLVL: rd_mux = rlvl_q;
            SEL_ONE:  rd_mux = DATA_W'(1);
            SEL_TICK: rd_mux = DATA_W'(tick_cnt);
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            err_pulse <= 1'b0;
        end else begin
            rd_valid  <= rd_en;
            rd_data   <= rd_en ? rd_mux : '0;
            err_pulse <= bad_acc;
        end
    end

endmodule

// File: rtl/sysreg_bank_chk.sv
module sysreg_bank_chk
    import sysreg_pkg::*;
#(
    parameter int unsigned TRIG_BIT = 8,
    parameter int unsigned FLAG_W   = 32,
    parameter int unsigned CNT_W    = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rd_valid,
    input logic              err_pulse,
    input logic              rst_req,
    input logic              key_open,
    input logic [FLAG_W-1:0] flags_v,
    input logic              tick_en,
    input logic [CNT_W-1:0]  tick_cnt
);

    assert_read_gives_valid_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rd_valid);

    assert_valid_only_after_read_R2: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(req_valid && !req_write));

    assert_bad_key_locks_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr == OFF_KEY && req_wdata != KEY_OPEN) |=> !key_open);

    assert_clear_drops_bits_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr == OFF_VCLR) |=> ((flags_v & $past(req_wdata[FLAG_W-1:0])) == '0));

    assert_locked_no_request_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && !key_open) |=> !rst_req);

    assert_request_has_cause_R9: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> $past(req_valid && req_write && req_addr == OFF_RLVL && key_open && req_wdata[TRIG_BIT]));

    assert_tick_steps_R10: assert property (@(posedge clk) disable iff (rst)
        tick_en |=> (tick_cnt == $past(tick_cnt) + CNT_W'(1)));

    assert_tick_holds_R10: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(tick_cnt));

    assert_err_after_access_R11: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> $past(req_valid));

endmodule

bind sysreg_bank sysreg_bank_chk #(
    .TRIG_BIT (TRIG_BIT),
    .FLAG_W   (FLAG_W),
    .CNT_W    (CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rd_valid  (rd_valid),
    .err_pulse (err_pulse),
    .rst_req   (rst_req),
    .key_open  (key_open),
    .flags_v   (flag_val[0]),
    .tick_en   (tick_en),
    .tick_cnt  (tick_cnt)
);

// File: tb/sysreg_bank_bench.sv
module sysreg_bank_bench;

    localparam logic [31:0] ID = 32'hC0DE_0042;
    localparam int unsigned TB = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwr_on_rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        err_pulse;
    logic        rst_req;

    int n_tests = 0;
    int n_fail  = 0;
    bit tick_gen = 1'b0;
    int cyc = 0;

    typedef struct {
        bit          wr;
        bit          chk_data;
        bit          is_tick;
        logic [31:0] exp_data;
        bit          exp_err;
        bit          exp_rst;
        string       tag;
    } item_t;

    item_t sb_q[$];

    sysreg_bank #(.ID_WORD(ID), .TRIG_BIT(TB)) u_sysreg_bank (
        .clk        (clk),
        .rst        (rst),
        .pwr_on_rst (pwr_on_rst),
        .tick_en    (tick_en),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .err_pulse  (err_pulse),
        .rst_req    (rst_req)
    );

    always #4 clk = ~clk;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Tick pattern: two cycles high, one low, while enabled.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        tick_en <= tick_gen && (cyc % 3 != 2);
    end

    // Driver: one request per call, pushed to the scoreboard.
    task automatic acc(bit wr, logic [11:0] a, logic [31:0] d, logic [31:0] exp,
                       bit chk, bit is_tick, bit eerr, bit erst, string tag);
        item_t it;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        it.wr = wr; it.chk_data = chk; it.is_tick = is_tick; it.exp_data = exp;
        it.exp_err = eerr; it.exp_rst = erst; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d, string tag);
        acc(1'b1, a, d, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
        acc(1'b0, a, 32'h0, exp, 1'b1, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic idle(int n);
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        for (int i = 1; i < n; i++) @(negedge clk);
    endtask

    // Monitor: pops at the request edge, compares two ns later.
    initial begin
        logic [31:0] model = '0;
        forever begin
            item_t it;
            bit    have;
            logic [31:0] snap;
            @(posedge clk);
            have = req_valid && !rst;
            if (have) it = sb_q.pop_front();
            snap = model;
            if (rst) model = '0;
            else if (tick_en) model = model + 1;
            #2;
            if (have) begin
                check({it.tag, " R2 rd_valid"}, {31'h0, rd_valid}, {31'h0, !it.wr});
                if (it.chk_data)
                    check(it.tag, rd_data, it.is_tick ? snap : it.exp_data);
                check({it.tag, " R11 err_pulse"}, {31'h0, err_pulse}, {31'h0, it.exp_err});
                check({it.tag, " R9 rst_req"}, {31'h0, rst_req}, {31'h0, it.exp_rst});
            end else if (!rst) begin
                check("R2/R9/R11 quiet idle", {29'h0, rd_valid, err_pulse, rst_req}, 32'h0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        pwr_on_rst = 1'b0;
        #1;
        check("R1 outputs after reset", {29'h0, rd_valid, err_pulse, rst_req}, 32'h0);

        // R1 reset values
        rd(12'h008, 32'h0, "R1 led");
        rd(12'h020, 32'h0, "R1 key");
        rd(12'h030, 32'h0, "R1 vflags");
        rd(12'h038, 32'h0, "R1 nvflags");
        rd(12'h040, 32'h0, "R1 rlvl");
        rd(12'h05C, 32'h0, "R1 tick");

        // R3 identity and constant
        rd(12'h000, ID, "R3 id");
        wr(12'h000, 32'hFFFF_FFFF, "R3 id write");
        rd(12'h000, ID, "R3 id after write");
        rd(12'h044, 32'h1, "R3 const one");

        // R4 LED
        wr(12'h008, 32'hA5A5_5A5A, "R4 led write");
        rd(12'h008, 32'hA5A5_5A5A, "R4 led read");

        // R5 / R8 / R9 key and reset level
        wr(12'h040, 32'h0000_0100, "R8 locked write");
        rd(12'h040, 32'h0, "R8 locked ignored");
        wr(12'h020, 32'h0000_FFFF, "R5 bad key");
        rd(12'h020, 32'h0000_7FFF, "R5 bit15 forced");
        wr(12'h020, 32'h0001_A05F, "R5 key with high bits");
        rd(12'h020, 32'h0000_205F, "R5 near key stored");
        wr(12'h040, 32'h0000_0100, "R8 still locked");
        rd(12'h040, 32'h0, "R8 still ignored");
        wr(12'h020, 32'h0000_A05F, "R5 open key");
        rd(12'h020, 32'h0000_A05F, "R5 key readback");
        acc(1'b1, 12'h040, 32'h0000_0104, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, "R9 trigger write");
        rd(12'h040, 32'h0000_0104, "R8 rlvl stored");
        wr(12'h040, 32'h0000_0004, "R9 other bit no pulse");
        rd(12'h040, 32'h0000_0004, "R8 rlvl stored 2");
        wr(12'h020, 32'h0000_1234, "R5 relock");
        wr(12'h040, 32'h0000_0100, "R9 relocked no pulse");
        rd(12'h040, 32'h0000_0004, "R8 relocked ignored");

        // R6 volatile flags
        wr(12'h030, 32'hF0F0_0000, "R6 set a");
        wr(12'h030, 32'h0000_000F, "R6 set b");
        rd(12'h030, 32'hF0F0_000F, "R6 or result");
        wr(12'h034, 32'h1000_0003, "R6 clear");
        rd(12'h030, 32'hE0F0_000C, "R6 clear result");
        rd(12'h034, 32'h0, "R6 clear addr reads zero");

        // R7 non-volatile flags
        wr(12'h038, 32'h8000_0001, "R7 set");
        wr(12'h03C, 32'h0000_0001, "R7 clear");
        rd(12'h038, 32'h8000_0000, "R7 value");
        idle(1);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        rd(12'h038, 32'h8000_0000, "R7 kept over rst");
        rd(12'h030, 32'h0, "R7 volatile cleared by rst");
        rd(12'h008, 32'h0, "R1 led cleared by rst");
        wr(12'h008, 32'h0000_00FF, "R7 led before por");
        idle(1);
        pwr_on_rst = 1'b1;
        @(negedge clk);
        pwr_on_rst = 1'b0;
        rd(12'h038, 32'h0, "R7 cleared by por");
        rd(12'h008, 32'h0000_00FF, "R7 por spares led");

        // R10 counter concurrent with tick
        tick_gen = 1'b1;
        for (int i = 0; i < 12; i++)
            acc(1'b0, 12'h05C, 32'h0, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, "R10 tick read");
        idle(4);
        for (int i = 0; i < 4; i++)
            acc(1'b0, 12'h05C, 32'h0, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, "R10 tick spaced");
        tick_gen = 1'b0;

        // R11 undefined offsets
        acc(1'b0, 12'h004, 32'h0, 32'h0, 1'b1, 1'b0, 1'b1, 1'b0, "R11 read 0x04");
        acc(1'b0, 12'h00A, 32'h0, 32'h0, 1'b1, 1'b0, 1'b1, 1'b0, "R11 unaligned read");
        acc(1'b1, 12'h00B, 32'hDEAD_BEEF, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, "R11 unaligned write");
        rd(12'h008, 32'h0000_00FF, "R11 led untouched");
        acc(1'b1, 12'hFFC, 32'h1234_5678, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, "R11 write top");
        acc(1'b0, 12'hFFC, 32'h0, 32'h0, 1'b1, 1'b0, 1'b1, 1'b0, "R11 read top");
        idle(3);

        check("R2 scoreboard drained", sb_q.size(), 32'h0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule